// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Register Bank

This block keeps one enable bit for each of 64 interrupt lines and exposes them to software through a small memory-mapped register port. The 64 lines are split into 32-bit groups. Each group can be reached at two addresses. A set alias turns enable bits on, and a clear alias turns them off. Both use write-one semantics, so bits written as zero are left as they are. Software can therefore change one line without a read-modify-write sequence, and it cannot race a second writer.

Reading either alias returns the same live enable state. The two aliases share one register; there is no separate copy. Every access to an alias must carry the privilege flag. An unprivileged access leaves the state alone, reads as zero and raises a one-cycle bus error. The enable vector is driven straight from the state registers to the interrupt logic downstream.

Top module: `irqen_bank`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `irq_en`, `bus_rdata` and `bus_err` are all zero, so every line is disabled.
- R2: The aliases for lines 0–31 are at 0x100 (set) and 0x180 (clear). The aliases for lines 32–63 are at 0x104 (set) and 0x184 (clear). Bit n of a group-g word maps to line 32·g+n.
- R3: A privileged write to a set alias sets each enable bit whose write data bit is 1 and leaves the bits written as 0 unchanged. The new state appears on `irq_en` in the cycle after the write strobe.
- R4: A privileged write to a clear alias clears each enable bit whose write data bit is 1 and leaves the bits written as 0 unchanged. The new state appears on `irq_en` in the cycle after the write strobe.
- R5: A privileged read of any of the four aliases returns that group's live enable state on `bus_rdata` in the cycle after the read strobe. A bit reads 1 when the line is enabled. If a read and a write are strobed in the same cycle, the read returns the state from before that write.
- R6: A read strobed in the cycle right after a write returns the state that the write produced.
- R7: An unprivileged read or write to an alias leaves `irq_en` unchanged and gives zero read data. It raises `bus_err` for exactly the cycle after that access.
- R8: An access to any other address leaves `irq_en` unchanged, returns zero on a read and raises no bus error.
- R9: `bus_rdata` is zero in every cycle that does not follow a privileged alias read, and `irq_en` changes only after a privileged alias write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | Registered error pulse for an unprivileged alias access |
| irq_en | output | NUM_LINES (64) | Live enable vector, one bit per line |

## Verification
The assertions assume that the strobes, the address, the write data and the privilege flag are sampled only at the clock edge. They also assume these inputs are free of unknowns while reset is low. A read and a write may arrive together, and the bench's expected values cover that case by taking the pre-write state for the read. The stimulus draws addresses from the four aliases plus nearby unmapped words. It draws the privilege flag, the strobes and the data at random, with a fixed seed. Every input is driven on the falling edge, so each one is stable at the rising edge that samples it.

// File: rtl/irqen_pkg.sv
package irqen_pkg;

  // Byte address of alias word g counted from a base address.
  function automatic int unsigned alias_addr(input int unsigned base, input int unsigned g);
    return base + 4 * g;
  endfunction

endpackage

// File: rtl/irqen_decode.sv
module irqen_decode #(
  parameter int ADDR_W   = 12,
  parameter int NGROUP   = 2,
  parameter int SET_BASE = 'h100,
  parameter int CLR_BASE = 'h180
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NGROUP-1:0] set_sel,
  output logic [NGROUP-1:0] clr_sel
);
  import irqen_pkg::*;

  // One exact-match comparator per alias word.
  for (genvar g = 0; g < NGROUP; g++) begin : g_alias
    localparam logic [ADDR_W-1:0] SetA = ADDR_W'(alias_addr(SET_BASE, g));
    localparam logic [ADDR_W-1:0] ClrA = ADDR_W'(alias_addr(CLR_BASE, g));
    assign set_sel[g] = (addr == SetA);
    assign clr_sel[g] = (addr == ClrA);
  end

endmodule

// File: rtl/irqen_group.sv
module irqen_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;

  assign set_mask = set_we ? wdata : '0;
  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else     en <= (en | set_mask) & ~clr_mask;
  end

endmodule

// File: rtl/irqen_resp.sv
module irqen_resp #(
  parameter int W      = 32,
  parameter int NGROUP = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_ok,
  input  logic [NGROUP-1:0]   rd_sel,
  input  logic [NGROUP*W-1:0] en_flat,
  input  logic                err_req,
  output logic [W-1:0]        rdata,
  output logic                err
);
  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int g = 0; g < NGROUP; g++)
      if (rd_sel[g]) pick = pick | en_flat[g*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= rd_ok ? pick : '0;
      err   <= err_req;
    end
  end

endmodule

// File: rtl/irqen_bank.sv
module irqen_bank #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int SET_BASE  = 'h100,
  parameter int CLR_BASE  = 'h180
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_priv,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_err,
  output logic [NUM_LINES-1:0] irq_en
);
  localparam int NGROUP = NUM_LINES / DATA_W;

  logic [NGROUP-1:0] set_sel;
  logic [NGROUP-1:0] clr_sel;
  logic [NGROUP-1:0] any_sel;
  logic              alias_hit;
  logic              wr_ok;
  logic              rd_ok;
  logic              err_req;

  irqen_decode #(
    .ADDR_W(ADDR_W), .NGROUP(NGROUP), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_decode (
    .addr(bus_addr), .set_sel(set_sel), .clr_sel(clr_sel)
  );

  assign any_sel   = set_sel | clr_sel;
  assign alias_hit = |any_sel;
  assign wr_ok     = bus_wr & bus_priv;
  assign rd_ok     = bus_rd & bus_priv & alias_hit;
  assign err_req   = alias_hit & (bus_rd | bus_wr) & ~bus_priv;

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    irqen_group #(.W(DATA_W)) u_group (
      .clk(clk), .rst(rst),
      .set_we(wr_ok & set_sel[g]),
      .clr_we(wr_ok & clr_sel[g]),
      .wdata(bus_wdata),
      .en(irq_en[g*DATA_W +: DATA_W])
    );
  end

  irqen_resp #(.W(DATA_W), .NGROUP(NGROUP)) u_resp (
    .clk(clk), .rst(rst),
    .rd_ok(rd_ok), .rd_sel(any_sel), .en_flat(irq_en),
    .err_req(err_req), .rdata(bus_rdata), .err(bus_err)
  );

endmodule

// File: rtl/irqen_bank_chk.sv
module irqen_bank_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int SET_BASE  = 'h100,
  parameter int CLR_BASE  = 'h180
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic                 bus_priv,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 bus_err,
  input logic [NUM_LINES-1:0] irq_en
);
  localparam logic [ADDR_W-1:0] Set0 = ADDR_W'(SET_BASE);
  localparam logic [ADDR_W-1:0] Clr0 = ADDR_W'(CLR_BASE);
  localparam logic [ADDR_W-1:0] Clr1 = ADDR_W'(CLR_BASE + 4);

  logic is_alias0;
  assign is_alias0 = (bus_addr == Set0) || (bus_addr == Clr0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (irq_en == '0 && !bus_err && bus_rdata == '0));

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_priv && bus_addr == Set0) |=>
      ((irq_en[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_priv && bus_addr == Clr1) |=>
      ((irq_en[2*DATA_W-1:DATA_W] & $past(bus_wdata)) == '0));

  // R4
  clr_other_grp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_priv && bus_addr == Clr0) |=> $stable(irq_en[2*DATA_W-1:DATA_W]));

  // R5
  read_live_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_priv && is_alias0) |=> (bus_rdata == $past(irq_en[DATA_W-1:0])));

  // R7
  unpriv_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_priv) |=> $stable(irq_en));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past((bus_rd || bus_wr) && !bus_priv));

  // R9
  no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr) |=> $stable(irq_en));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || !bus_priv) |=> (bus_rdata == '0));

endmodule

bind irqen_bank irqen_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES),
  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_en(irq_en)
);

// File: tb/irqen_bank_bench.sv
module irqen_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [63:0] irq_en;

  int checks = 0;
  int errors = 0;
  logic [63:0] model = '0;

  always #5 clk = ~clk;

  irqen_bank u_irqen_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_en(irq_en)
  );

  // Address map from R2: group index, or -1 when unmapped.
  function automatic int grp_of(input logic [11:0] a);
    case (a)
      12'h100, 12'h180: return 0;
      12'h104, 12'h184: return 1;
      default:          return -1;
    endcase
  endfunction

  function automatic logic is_set(input logic [11:0] a);
    return (a == 12'h100) || (a == 12'h104);
  endfunction

  function automatic logic [63:0] next_state(input logic [63:0] s, input logic wr, input logic priv,
                                             input logic [11:0] a, input logic [31:0] d);
    logic [63:0] m;
    int g;
    g = grp_of(a);
    if (!wr || !priv || g < 0) return s;
    m = 64'(d) << (32 * g);
    return is_set(a) ? (s | m) : (s & ~m);
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: drive on the falling edge, check at the next falling edge.
  task automatic step(input logic wr, input logic rd, input logic priv, input logic [11:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    logic        exp_err;
    int g;
    string t_en, t_rd, t_err;
    g = grp_of(a);
    exp_rd  = (rd && priv && g >= 0) ? model[32*g +: 32] : 32'h0;
    exp_err = (g >= 0) && (rd || wr) && !priv;
    if (g < 0)                 begin t_en = "R8"; t_rd = "R8"; end
    else if (!priv)            begin t_en = "R7"; t_rd = "R7"; end
    else if (wr && is_set(a))  begin t_en = "R3"; t_rd = "R5"; end
    else if (wr)               begin t_en = "R4"; t_rd = "R5"; end
    else                       begin t_en = "R9"; t_rd = "R5"; end
    if (!rd) t_rd = "R9";
    t_err = "R7";
    if (tag != "") begin t_en = tag; t_rd = tag; t_err = tag; end
    model = next_state(model, wr, priv, a, d);
    bus_wr = wr; bus_rd = rd; bus_priv = priv; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check64(t_en, irq_en, model);
    check64(t_rd, 64'(bus_rdata), 64'(exp_rd));
    check64(t_err, 64'(bus_err), 64'(exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] pool [8];
    void'($urandom(32'd20240611));
    pool[0] = 12'h100; pool[1] = 12'h104; pool[2] = 12'h180; pool[3] = 12'h184;
    pool[4] = 12'h108; pool[5] = 12'h188; pool[6] = 12'h000; pool[7] = 12'h0FC;

    repeat (3) @(negedge clk);
    check64("R1", irq_en, 64'h0);
    check64("R1", 64'(bus_rdata), 64'h0);
    check64("R1", 64'(bus_err), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check64("R1", irq_en, 64'h0);

    // R2: line 32 lives in bit 0 of the second set word.
    step(1, 0, 1, 12'h104, 32'h1, "R2");
    check64("R2", 64'(irq_en[32]), 64'h1);
    // R3: set in group 0, zeros leave bits alone.
    step(1, 0, 1, 12'h100, 32'hA5A5_0001, "");
    step(1, 0, 1, 12'h100, 32'h0, "");
    // R6: read right after a write sees the new value.
    step(1, 0, 1, 12'h180, 32'h0000_0001, "R6");
    step(0, 1, 1, 12'h100, 32'h0, "R6");
    // R5: read and write together return the old state.
    step(1, 1, 1, 12'h184, 32'hFFFF_FFFF, "R5");
    step(0, 1, 1, 12'h104, 32'h0, "R5");
    // R7: unprivileged write and read.
    step(1, 0, 0, 12'h180, 32'hFFFF_FFFF, "R7");
    step(0, 1, 0, 12'h100, 32'h0, "R7");
    // R8: unmapped write and read.
    step(1, 1, 1, 12'h108, 32'hFFFF_FFFF, "R8");
    // R9: idle cycle.
    step(0, 0, 1, 12'h100, 32'hFFFF_FFFF, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic wr, rd, priv;
      wr   = ($urandom % 2) == 0;
      rd   = ($urandom % 3) == 0;
      priv = ($urandom % 5) != 0;
      step(wr, rd, priv, pool[$urandom % 8], $urandom, "");
    end

    rst = 1'b1;
    @(negedge clk);
    model = '0;
    check64("R1", irq_en, 64'h0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule